// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block produces the frame timing of a multi-slot time-division-multiplexed audio port. It runs on the bit clock: every clock edge is one bit time on the serial lines. It gives the serializers of both directions a common view of where the current bit sits in the frame: a frame-start strobe, the slot index, and the bit offset within that slot. It also produces a frame sync waveform of the selected shape.

In master mode the frame length comes from a divider setting: a frame lasts the divider value plus one bit clocks. In slave mode the block watches the sync line from the codec. It stays quiet until it recognises a frame boundary, and from then on it free-runs between boundaries. Every recognised boundary snaps it back to bit 0.

The sync is either a one-bit pulse or a pulse one slot wide. The one-bit pulse can sit on the first bit of the frame or on the last bit of the frame before. Some settings cannot hold the slots they describe. For these the block raises an error flag and keeps every timing output at zero.

Top module: `tdm_fs_gen`

## Requirements
- R1: When enabled in master mode with a valid setting, the bit position counts 0,1,…,frame_div and wraps to 0, so a frame lasts frame_div+1 clocks. frame_start is high exactly in the cycles at position 0.
- R2: slot_len_sel selects the slot length: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits, and 3 is invalid. bit_pos is the position modulo the slot length, and slot_idx is the position divided by the slot length.
- R3: With long_sync=0 and early_pulse=0, fsync is high only in the frame's first bit (position 0).
- R4: With long_sync=0 and early_pulse=1, fsync is high only in the frame's last bit (position frame_div). With long_sync=1, early_pulse has no effect.
- R5: With long_sync=1, fsync is high while the position is below the slot length and low for the rest of the frame.
- R6: While enable=0, fsync, frame_start, slot_idx, bit_pos and cfg_err are all 0. The first enabled cycle is position 0.
- R7: A setting is invalid if slot_len_sel=3, or slot_count=0, or frame_div+1 is less than the slot length times slot_count. While enabled with an invalid setting, cfg_err=1 and all other outputs are 0.
- R8: With long_sync=1 and slot_count=1, the setting is also invalid unless frame_div+1 is strictly greater than the slot length. With a short sync, frame_div+1 equal to the slot length is valid.
- R9: In slave mode (slave_mode=1) the outputs stay 0 until the first frame boundary is recognised. In short-late and long mode, a cycle where ext_fsync is 1 after a 0 is position 0. In short-early mode, the cycle after such a rise is position 0.
- R10: In slave mode, every recognised boundary forces position 0, even in the middle of a frame. Between boundaries the position advances and wraps at frame_div.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable for all frame activity |
| slave_mode | input | 1 | 0: generate timing, 1: follow ext_fsync |
| long_sync | input | 1 | 0: one-bit sync, 1: one-slot-wide sync |
| early_pulse | input | 1 | One-bit sync on the last bit of the previous frame (short mode only) |
| slot_len_sel | input | 2 | Slot length code: 0=8, 1=16, 2=32 bits |
| slot_count | input | CNT_W (4) | Number of slots per frame |
| frame_div | input | DIV_W (10) | Frame length minus one, in bit clocks |
| ext_fsync | input | 1 | Frame sync from the codec (slave mode) |
| fsync | output | 1 | Frame sync waveform |
| frame_start | output | 1 | High in the first bit of each frame |
| slot_idx | output | DIV_W-3 (7) | Current slot number |
| bit_pos | output | 5 | Bit offset within the current slot |
| cfg_err | output | 1 | Enabled with an invalid setting |

## Verification
The hardest case to reach from the ports is a slave realignment. The codec's sync phase jumps while the block is in the middle of a frame, so a boundary arrives at a position other than frame_div. In the early-pulse form the boundary is also recognised one cycle after the sync rises. The stimulus drives ext_fsync from an independent phase counter and moves that counter by a fixed amount partway through each slave run. This makes the block abandon a partly counted frame. The limit settings for R7 and R8 are reached by setting frame_div to exactly one below the minimum length, and then to exactly the minimum length.

// File: rtl/tdm_fs_pkg.sv
`timescale 1ns/1ps
package tdm_fs_pkg;

    localparam int MIN_SLOT_LOG2 = 3;
    localparam int MAX_SLOT_LOG2 = 5;

    typedef enum logic [1:0] {
        SLOT_8   = 2'd0,
        SLOT_16  = 2'd1,
        SLOT_32  = 2'd2,
        SLOT_BAD = 2'd3
    } slot_len_e;

    typedef enum logic [1:0] {
        SHAPE_SHORT_LATE  = 2'd0,
        SHAPE_SHORT_EARLY = 2'd1,
        SHAPE_LONG        = 2'd2
    } sync_shape_e;

    function automatic logic [2:0] slot_log2(input slot_len_e code);
        case (code)
            SLOT_16: slot_log2 = 3'd4;
            SLOT_32: slot_log2 = 3'd5;
            default: slot_log2 = 3'd3;
        endcase
    endfunction

    function automatic sync_shape_e shape_of(input logic long_s, input logic early_s);
        if (long_s)       shape_of = SHAPE_LONG;
        else if (early_s) shape_of = SHAPE_SHORT_EARLY;
        else              shape_of = SHAPE_SHORT_LATE;
    endfunction

endpackage

// File: rtl/tdm_fs_cfg_check.sv
`timescale 1ns/1ps
module tdm_fs_cfg_check
    import tdm_fs_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int CNT_W = 4
) (
    input  logic             long_sync,
    input  logic [1:0]       slot_len_sel,
    input  logic [CNT_W-1:0] slot_count,
    input  logic [DIV_W-1:0] frame_div,
    output logic             cfg_ok,
    output logic [2:0]       sl_log2
);
    localparam int CMP_W = DIV_W + CNT_W + MAX_SLOT_LOG2 + 1;

    logic [CMP_W-1:0] frame_len;
    logic [CMP_W-1:0] need_len;
    logic [CMP_W-1:0] one_slot;
    logic             code_ok;
    logic             fits;
    logic             long_single_ok;

    always_comb begin
        sl_log2        = slot_log2(slot_len_e'(slot_len_sel));
        frame_len      = CMP_W'(frame_div) + CMP_W'(1);
        one_slot       = CMP_W'(1) << sl_log2;
        need_len       = CMP_W'(slot_count) << sl_log2;
        code_ok        = (slot_len_e'(slot_len_sel) != SLOT_BAD) && (slot_count != '0);
        fits           = frame_len >= need_len;
        long_single_ok = !(long_sync && (slot_count == CNT_W'(1)) && (frame_len <= one_slot));
        cfg_ok         = code_ok && fits && long_single_ok;
    end

endmodule

// File: rtl/tdm_fs_ext_track.sv
`timescale 1ns/1ps
module tdm_fs_ext_track
    import tdm_fs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_fsync,
    input  sync_shape_e shape,
    output logic        ext_start
);
    logic ext_d;
    logic ext_dd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_d  <= 1'b0;
            ext_dd <= 1'b0;
        end else begin
            ext_d  <= ext_fsync;
            ext_dd <= ext_d;
        end
    end

    always_comb begin
        if (shape == SHAPE_SHORT_EARLY) ext_start = ext_d && !ext_dd;
        else                            ext_start = ext_fsync && !ext_d;
    end

    // R9: a recognised boundary is one cycle wide
    assert_start_single_R9: assert property (@(posedge clk) disable iff (rst)
        ext_start |=> !ext_start);

    // R9: in early form the boundary follows a high sync bit
    assert_early_after_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (shape == SHAPE_SHORT_EARLY) && ext_start |-> $past(ext_fsync));

endmodule

// File: rtl/tdm_fs_counter.sv
`timescale 1ns/1ps
module tdm_fs_counter #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             slave_mode,
    input  logic             ext_start,
    input  logic [DIV_W-1:0] frame_div,
    output logic             run,
    output logic [DIV_W-1:0] cur_pos
);
    logic [DIV_W-1:0] pos_q;
    logic             locked_q;
    logic             realign;

    always_comb begin
        realign = slave_mode && ext_start;
        run     = active && (!slave_mode || locked_q || ext_start);
        if (!run || realign) cur_pos = '0;
        else                 cur_pos = pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pos_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            if (run) begin
                if (cur_pos >= frame_div) pos_q <= '0;
                else                      pos_q <= cur_pos + DIV_W'(1);
            end else begin
                pos_q <= '0;
            end
            if (!slave_mode)  locked_q <= 1'b0;
            else if (realign) locked_q <= 1'b1;
        end
    end

    // R1: inside a master frame the position steps by one per clock
    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        run && !slave_mode && (cur_pos < frame_div)
        |=> (!run || slave_mode || (cur_pos == $past(cur_pos) + DIV_W'(1))));

endmodule

// File: rtl/tdm_fs_gen.sv
`timescale 1ns/1ps
module tdm_fs_gen
    import tdm_fs_pkg::*;
#(
    parameter int DIV_W     = 10,
    parameter int MAX_SLOTS = 8,
    localparam int CNT_W    = $clog2(MAX_SLOTS + 1),
    localparam int IDX_W    = DIV_W - MIN_SLOT_LOG2,
    localparam int BIT_W    = MAX_SLOT_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             slave_mode,
    input  logic             long_sync,
    input  logic             early_pulse,
    input  logic [1:0]       slot_len_sel,
    input  logic [CNT_W-1:0] slot_count,
    input  logic [DIV_W-1:0] frame_div,
    input  logic             ext_fsync,
    output logic             fsync,
    output logic             frame_start,
    output logic [IDX_W-1:0] slot_idx,
    output logic [BIT_W-1:0] bit_pos,
    output logic             cfg_err
);
    sync_shape_e      shape;
    logic             cfg_ok;
    logic [2:0]       sl_log2;
    logic             ext_start;
    logic             active;
    logic             run;
    logic [DIV_W-1:0] cur_pos;
    logic [DIV_W-1:0] slot_span;

    assign shape  = shape_of(long_sync, early_pulse);
    assign active = enable && cfg_ok;

    tdm_fs_cfg_check #(.DIV_W(DIV_W), .CNT_W(CNT_W)) cfg_i (
        .long_sync    (long_sync),
        .slot_len_sel (slot_len_sel),
        .slot_count   (slot_count),
        .frame_div    (frame_div),
        .cfg_ok       (cfg_ok),
        .sl_log2      (sl_log2)
    );

    tdm_fs_ext_track ext_i (
        .clk       (clk),
        .rst       (rst),
        .ext_fsync (ext_fsync),
        .shape     (shape),
        .ext_start (ext_start)
    );

    tdm_fs_counter #(.DIV_W(DIV_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .slave_mode (slave_mode),
        .ext_start  (ext_start),
        .frame_div  (frame_div),
        .run        (run),
        .cur_pos    (cur_pos)
    );

    always_comb begin
        slot_span   = DIV_W'(1) << sl_log2;
        cfg_err     = enable && !cfg_ok;
        frame_start = run && (cur_pos == '0);
        slot_idx    = IDX_W'(cur_pos >> sl_log2);
        bit_pos     = BIT_W'(cur_pos & (slot_span - DIV_W'(1)));
        case (shape)
            SHAPE_LONG:        fsync = run && (cur_pos < slot_span);
            SHAPE_SHORT_EARLY: fsync = run && (cur_pos == frame_div);
            default:           fsync = run && (cur_pos == '0);
        endcase
    end

    // R7: an invalid setting silences all timing outputs
    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!fsync && !frame_start && (slot_idx == '0) && (bit_pos == '0)));

    // R6: disabled means silent
    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!fsync && !frame_start && !cfg_err));

    // R3: a master late pulse lasts a single bit clock
    assert_short_single_R3: assert property (@(posedge clk) disable iff (rst)
        enable && !slave_mode && !long_sync && !early_pulse && fsync
        |=> (!fsync || !$stable(frame_div) || !$stable(long_sync)
             || !$stable(early_pulse) || !$stable(slave_mode)));

    // R5: a long sync never spills past the first slot
    assert_long_first_slot_R5: assert property (@(posedge clk) disable iff (rst)
        long_sync && fsync |-> (slot_idx == '0));

    // R10: a recognised boundary in slave mode is always bit 0
    assert_slave_align_R10: assert property (@(posedge clk) disable iff (rst)
        enable && slave_mode && !cfg_err && ext_start |-> (frame_start && (bit_pos == '0)));

endmodule

// File: tb/tdm_fs_gen_tb_top.sv
`timescale 1ns/1ps
module tdm_fs_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 10;
    localparam int CNT_W = 4;

    typedef struct {
        bit    fs;
        bit    st;
        int    idx;
        int    bp;
        bit    err;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, slave_mode = 1'b0, long_sync = 1'b0, early_pulse = 1'b0;
    logic [1:0] slot_len_sel = 2'd0;
    logic [CNT_W-1:0] slot_count = '0;
    logic [DIV_W-1:0] frame_div = '0;
    logic ext_fsync = 1'b0;
    logic fsync, frame_start, cfg_err;
    logic [DIV_W-4:0] slot_idx;
    logic [4:0] bit_pos;

    exp_t sb_q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state
    int  m_pos = 0;
    bit  m_lock = 0;
    bit  h1 = 0, h2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_fs_gen #(.DIV_W(DIV_W), .MAX_SLOTS(8)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .slave_mode(slave_mode),
        .long_sync(long_sync), .early_pulse(early_pulse), .slot_len_sel(slot_len_sel),
        .slot_count(slot_count), .frame_div(frame_div), .ext_fsync(ext_fsync),
        .fsync(fsync), .frame_start(frame_start), .slot_idx(slot_idx),
        .bit_pos(bit_pos), .cfg_err(cfg_err)
    );

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (!finished && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (fsync !== e.fs || frame_start !== e.st || int'(slot_idx) != e.idx
                || int'(bit_pos) != e.bp || cfg_err !== e.err) begin
                n_bad++;
                $display("FAIL %s t=%0t: got fs=%0b st=%0b idx=%0d bit=%0d err=%0b, expected fs=%0b st=%0b idx=%0d bit=%0d err=%0b",
                    e.req, $time, fsync, frame_start, slot_idx, bit_pos, cfg_err,
                    e.fs, e.st, e.idx, e.bp, e.err);
            end
        end
    end

    // driver: apply one cycle of inputs, push its expected outputs
    task automatic cyc(input bit en, input bit sl, input bit lg, input bit ea,
                       input int code, input int cnt, input int dv, input bit ext,
                       input string req);
        int  slen, cur;
        bit  ok, act, start, run;
        exp_t e;
        enable = en; slave_mode = sl; long_sync = lg; early_pulse = ea;
        slot_len_sel = code[1:0]; slot_count = CNT_W'(cnt); frame_div = DIV_W'(dv);
        ext_fsync = ext;
        slen  = 8 << ((code == 3) ? 0 : code);
        ok    = (code != 3) && (cnt != 0) && (dv + 1 >= slen * cnt)
                && !(lg && cnt == 1 && dv + 1 <= slen);
        act   = en && ok;
        start = sl && act && (ea && !lg ? (h1 && !h2) : (ext && !h1));
        run   = act && (!sl || m_lock || start);
        cur   = (!run || start) ? 0 : m_pos;
        e.fs  = run && (lg ? (cur < slen) : (ea ? (cur == dv) : (cur == 0)));
        e.st  = run && cur == 0;
        e.idx = cur / slen;
        e.bp  = cur % slen;
        e.err = en && !ok;
        e.req = req;
        sb_q.push_back(e);
        if (!act) begin m_pos = 0; m_lock = 0; end
        else begin
            m_pos = run ? ((cur >= dv) ? 0 : cur + 1) : 0;
            if (!sl) m_lock = 0; else if (start) m_lock = 1;
        end
        h2 = h1; h1 = ext;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, "R6 idle");
    endtask

    task automatic master_run(input bit lg, input bit ea, input int code, input int cnt,
                              input int dv, input int n, input string req);
        for (int i = 0; i < n; i++) cyc(1, 0, lg, ea, code, cnt, dv, 0, req);
    endtask

    task automatic slave_run(input bit lg, input bit ea, input int code, input int cnt,
                             input int dv, input int ph0, input int n, input int jump_at,
                             input int jump_to, input string req);
        int ph = ph0;
        int slen = 8 << code;
        for (int k = 0; k < n; k++) begin
            bit ext;
            ext = lg ? (ph < slen) : (ea ? (ph == dv) : (ph == 0));
            cyc(1, 1, lg, ea, code, cnt, dv, ext, req);
            ph = (k == jump_at) ? jump_to : ((ph >= dv) ? 0 : ph + 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle(3);                                          // R6 reset state
        master_run(0, 0, 0, 4, 31, 70, "R1 R2 R3 short late");
        idle(2);
        master_run(0, 1, 1, 2, 39, 90, "R4 R2 short early");
        idle(2);
        master_run(1, 1, 1, 2, 35, 80, "R5 R4 long, early ignored");
        idle(2);
        master_run(1, 0, 2, 2, 70, 80, "R5 R2 long 32-bit slots");
        master_run(0, 0, 1, 2, 30, 5, "R7 frame too short");
        master_run(0, 0, 3, 1, 63, 3, "R7 bad slot code");
        master_run(0, 0, 0, 0, 63, 3, "R7 zero slots");
        master_run(1, 0, 0, 1, 7, 4, "R8 long single slot equal length");
        master_run(1, 0, 0, 1, 8, 30, "R8 long single slot one longer");
        master_run(0, 0, 0, 1, 7, 20, "R8 short single slot equal length");
        idle(2);
        master_run(0, 0, 0, 2, 19, 10, "R6 before drop");
        idle(2);
        master_run(0, 0, 0, 2, 19, 25, "R6 restart at zero");
        idle(2);
        slave_run(0, 0, 0, 4, 31, 29, 110, 60, 9, "R9 R10 slave late");
        idle(2);
        slave_run(0, 1, 1, 2, 39, 35, 120, 70, 12, "R9 R10 slave early");
        idle(2);
        slave_run(1, 0, 1, 2, 35, 30, 120, 50, 20, "R9 R10 slave long");
        idle(2);
        @(negedge clk); @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule